// File: doc/BRIEF.md
# Exchange-Add / Compare-Exchange Sequencer

This block owns a small register file (eight 16-bit entries by default, entry 0 serving as the accumulator) and runs two read-modify-write register operations on it. It supports exchange-and-add and compare-and-exchange against the accumulator. A one-cycle start pulse carries the opcode, a destination index and a source index. The unit then moves through a fixed state sequence: idle, read, first write, second write, done. It uses the single register-file write port once per write state, and it raises a one-cycle done pulse when the operation has completed.

Exchange-and-add stores the old destination value into the source entry first, then stores the sum into the destination entry. With this order, an operation whose source and destination name the same entry leaves the sum in that entry. Compare-and-exchange subtracts the destination from the accumulator and records the flags of that compare. On equality it copies the source value into the destination. Otherwise it copies the destination value into the accumulator. A preload port writes an entry while the unit is idle, and a combinational observe port reads any entry, so the surrounding logic can set and inspect state.

Top module: `xcu_unit`

## Requirements
- R1: After reset every register entry reads 0, the flag vector is 0, and done and busy are low.
- R2: Exchange-and-add with distinct indices leaves the old destination value in the source entry and (old destination + source) mod 2^16 in the destination entry. All other entries are unchanged.
- R3: Exchange-and-add with equal source and destination indices leaves twice the old value (mod 2^16) in that entry, because the destination write comes last.
- R4: Exchange-and-add sets the flag vector as an addition of old destination and source. The bit positions are: bit0 carry out, bit1 even parity of the low result byte, bit2 carry out of bit 3, bit3 result zero, bit4 result sign, bit5 signed overflow.
- R5: Compare-and-exchange sets the flag vector, with the same bit positions, as the subtraction accumulator minus destination. Bit0 is then the borrow (accumulator below destination, unsigned) and bit2 is the borrow out of bit 3.
- R6: Compare-and-exchange with accumulator equal to destination writes the source value into the destination entry, sets bit3 and leaves the accumulator unchanged. With destination index 0 this case always applies.
- R7: Compare-and-exchange with accumulator unequal to destination copies the destination value into the accumulator, clears bit3 and leaves the destination unchanged.
- R8: done is high for exactly one cycle. It is seen in the 4th cycle after the start cycle for exchange-and-add (opcode 0) and in the 3rd for compare-and-exchange (opcode 1).
- R9: A start pulse, with any opcode and indices, is ignored while busy is high. It neither changes the running operation nor causes a second done.
- R10: A preload writes its data into the indexed entry at the next edge when the unit is idle, and it is ignored while busy is high.
- R11: The flag vector holds its value between operations and is not changed by preloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 1 | 0 exchange-and-add, 1 compare-and-exchange |
| dst_i | input | 3 | Destination entry index |
| src_i | input | 3 | Source entry index |
| ld_en_i | input | 1 | Preload strobe |
| ld_idx_i | input | 3 | Preload entry index |
| ld_data_i | input | 16 | Preload data |
| obs_idx_i | input | 3 | Observe entry index |
| obs_data_o | output | 16 | Observed entry value (combinational) |
| flags_o | output | 6 | Flag vector of the last operation |
| busy_o | output | 1 | High from the cycle after start until done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The cases hardest to reach from the ports are the aliased ones. The first is exchange-and-add with one index in both roles. The second is compare-and-exchange whose destination is the accumulator itself, which forces equality. Both are reached by sweeping all 64 index pairs for both opcodes, with every entry reloaded before each run. Equality for the other compare-and-exchange pairs is forced on alternate runs by copying the destination value into the accumulator. A start and a preload injected during the read cycle, with different indices, check that the latched indices and the busy guards hold.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  localparam int FLAG_W = 6;
  localparam int FB_C = 0;
  localparam int FB_P = 1;
  localparam int FB_A = 2;
  localparam int FB_Z = 3;
  localparam int FB_S = 4;
  localparam int FB_O = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_WR1  = 3'd2,
    ST_WR2  = 3'd3,
    ST_DONE = 3'd4
  } xcu_state_e;

  typedef enum logic {
    OP_XADD = 1'b0,
    OP_CMPX = 1'b1
  } xcu_op_e;
endpackage

// File: rtl/xcu_regfile.sv
module xcu_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [W-1:0]    wdata,
  input  logic [IDXW-1:0] ra_dst,
  input  logic [IDXW-1:0] ra_src,
  input  logic [IDXW-1:0] ra_acc,
  input  logic [IDXW-1:0] ra_obs,
  output logic [W-1:0]    rd_dst,
  output logic [W-1:0]    rd_src,
  output logic [W-1:0]    rd_acc,
  output logic [W-1:0]    rd_obs
);
  logic [W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (we && (widx == IDXW'(g))) begin
        q[g] <= wdata;
      end
    end
  end

  assign rd_dst = q[ra_dst];
  assign rd_src = q[ra_src];
  assign rd_acc = q[ra_acc];
  assign rd_obs = q[ra_obs];
endmodule

// File: rtl/xcu_alu.sv
module xcu_alu
  import xcu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      dst_val,
  input  logic [W-1:0]      src_val,
  input  logic [W-1:0]      acc_val,
  input  logic              op_cmpx,
  output logic [W-1:0]      sum,
  output logic              equal,
  output logic [FLAG_W-1:0] flags
);
  function automatic logic [FLAG_W-1:0] add_flags(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    logic [FLAG_W-1:0] f;
    s = {1'b0, a} + {1'b0, b};
    f = '0;
    f[FB_C] = s[W];
    f[FB_P] = ~^s[7:0];
    f[FB_A] = a[4] ^ b[4] ^ s[4];
    f[FB_Z] = (s[W-1:0] == '0);
    f[FB_S] = s[W-1];
    f[FB_O] = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    return f;
  endfunction

  function automatic logic [FLAG_W-1:0] sub_flags(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] d;
    logic [FLAG_W-1:0] f;
    d = {1'b0, a} - {1'b0, b};
    f = '0;
    f[FB_C] = d[W];
    f[FB_P] = ~^d[7:0];
    f[FB_A] = a[4] ^ b[4] ^ d[4];
    f[FB_Z] = (d[W-1:0] == '0);
    f[FB_S] = d[W-1];
    f[FB_O] = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
    return f;
  endfunction

  assign sum   = dst_val + src_val;
  assign equal = (acc_val == dst_val);
  assign flags = op_cmpx ? sub_flags(acc_val, dst_val) : add_flags(dst_val, src_val);
endmodule

// File: rtl/xcu_seq.sv
module xcu_seq
  import xcu_pkg::*;
#(
  parameter int W       = 16,
  parameter int NREG    = 8,
  parameter int ACC_IDX = 0,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op,
  input  logic [IDXW-1:0]   dst_idx,
  input  logic [IDXW-1:0]   src_idx,
  input  logic [W-1:0]      rd_dst,
  input  logic [W-1:0]      rd_src,
  input  logic [W-1:0]      alu_sum,
  input  logic              alu_equal,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [IDXW-1:0]   ra_dst,
  output logic [IDXW-1:0]   ra_src,
  output logic              op_cmpx,
  output logic              we,
  output logic [IDXW-1:0]   widx,
  output logic [W-1:0]      wdata,
  output logic [FLAG_W-1:0] flags_q,
  output logic              busy,
  output logic              done,
  output logic              ev_accept,
  output logic              ev_wr1,
  output logic              ev_wr2
);
  localparam logic [IDXW-1:0] ACC = IDXW'(ACC_IDX);

  xcu_state_e state_q, state_d;
  logic [IDXW-1:0] dst_q, src_q;
  logic            op_q;
  logic [W-1:0]    dold_q, sval_q, sum_q;
  logic            eq_q;

  assign ev_accept = start && (state_q == ST_IDLE);
  assign ev_wr1    = (state_q == ST_WR1);
  assign ev_wr2    = (state_q == ST_WR2);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign ra_dst    = dst_q;
  assign ra_src    = src_q;
  assign op_cmpx   = op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_WR1;
      ST_WR1:  state_d = (op_q == OP_XADD) ? ST_WR2 : ST_DONE;
      ST_WR2:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      op_q    <= OP_XADD;
      dold_q  <= '0;
      sval_q  <= '0;
      sum_q   <= '0;
      eq_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        dst_q <= dst_idx;
        src_q <= src_idx;
        op_q  <= op;
      end
      if (state_q == ST_READ) begin
        dold_q  <= rd_dst;
        sval_q  <= rd_src;
        sum_q   <= alu_sum;
        eq_q    <= alu_equal;
        flags_q <= alu_flags;
      end
    end
  end

  // Write order: exchange-add puts the old destination into the source first,
  // then the sum into the destination, so an aliased entry ends with the sum.
  always_comb begin
    we    = 1'b0;
    widx  = dst_q;
    wdata = sum_q;
    if (ev_wr1) begin
      we = 1'b1;
      if (op_q == OP_XADD) begin
        widx  = src_q;
        wdata = dold_q;
      end else if (eq_q) begin
        widx  = dst_q;
        wdata = sval_q;
      end else begin
        widx  = ACC;
        wdata = dold_q;
      end
    end else if (ev_wr2) begin
      we    = 1'b1;
      widx  = dst_q;
      wdata = sum_q;
    end
  end
endmodule

// File: rtl/xcu_unit.sv
module xcu_unit
  import xcu_pkg::*;
#(
  parameter int W       = 16,
  parameter int NREG    = 8,
  parameter int ACC_IDX = 0,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [IDXW-1:0]   dst_i,
  input  logic [IDXW-1:0]   src_i,
  input  logic              ld_en_i,
  input  logic [IDXW-1:0]   ld_idx_i,
  input  logic [W-1:0]      ld_data_i,
  input  logic [IDXW-1:0]   obs_idx_i,
  output logic [W-1:0]      obs_data_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [IDXW-1:0] ACC = IDXW'(ACC_IDX);

  logic [IDXW-1:0]   ra_dst, ra_src, seq_widx, rf_widx;
  logic [W-1:0]      rd_dst, rd_src, rd_acc, seq_wdata, rf_wdata, alu_sum;
  logic              seq_we, ld_we, rf_we, alu_equal, op_cmpx;
  logic [FLAG_W-1:0] alu_flags;
  logic              ev_accept, ev_wr1, ev_wr2;

  assign ld_we    = ld_en_i && !busy_o;
  assign rf_we    = seq_we || ld_we;
  assign rf_widx  = seq_we ? seq_widx  : ld_idx_i;
  assign rf_wdata = seq_we ? seq_wdata : ld_data_i;

  xcu_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ra_dst(ra_dst), .ra_src(ra_src), .ra_acc(ACC), .ra_obs(obs_idx_i),
    .rd_dst(rd_dst), .rd_src(rd_src), .rd_acc(rd_acc), .rd_obs(obs_data_o)
  );

  xcu_alu #(.W(W)) u_alu (
    .dst_val(rd_dst), .src_val(rd_src), .acc_val(rd_acc), .op_cmpx(op_cmpx),
    .sum(alu_sum), .equal(alu_equal), .flags(alu_flags)
  );

  xcu_seq #(.W(W), .NREG(NREG), .ACC_IDX(ACC_IDX)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start_i), .op(op_i), .dst_idx(dst_i), .src_idx(src_i),
    .rd_dst(rd_dst), .rd_src(rd_src),
    .alu_sum(alu_sum), .alu_equal(alu_equal), .alu_flags(alu_flags),
    .ra_dst(ra_dst), .ra_src(ra_src), .op_cmpx(op_cmpx),
    .we(seq_we), .widx(seq_widx), .wdata(seq_wdata),
    .flags_q(flags_o), .busy(busy_o), .done(done_o),
    .ev_accept(ev_accept), .ev_wr1(ev_wr1), .ev_wr2(ev_wr2)
  );
endmodule

// File: rtl/xcu_unit_chk.sv
module xcu_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic seq_we,
  input logic ld_we,
  input logic ev_wr1,
  input logic ev_wr2
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(ev_wr1) || $past(ev_wr2)));

  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r3_dst_write_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr2 |-> $past(ev_wr1));

  a_r10_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_we && ld_we));

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

bind xcu_unit xcu_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .seq_we(seq_we), .ld_we(ld_we), .ev_wr1(ev_wr1), .ev_wr2(ev_wr2)
);

// File: tb/xcu_unit_tb.sv
module xcu_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, op_i = 1'b0;
  logic [2:0]  dst_i = '0, src_i = '0, ld_idx_i = '0, obs_idx_i = '0;
  logic        ld_en_i = 1'b0;
  logic [15:0] ld_data_i = '0;
  logic [15:0] obs_data_o;
  logic [5:0]  flags_o;
  logic        busy_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] model [8];
  logic [5:0]  exp_flags;

  always #2.5 clk = ~clk;

  xcu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
    .ld_data_i(ld_data_i), .obs_idx_i(obs_idx_i), .obs_data_o(obs_data_o),
    .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // flag vector {OF,SF,ZF,AF,PF,CF} written from integer arithmetic
  function automatic logic [5:0] ref_flags(input bit is_sub, input logic [15:0] a, input logic [15:0] b);
    int ua, ub, sa, sb, r, sr;
    logic [15:0] res;
    logic cf, af, of_;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    if (is_sub) begin
      r = ua - ub; sr = sa - sb;
      cf = (ua < ub);
      af = ((ua % 16) < (ub % 16));
    end else begin
      r = ua + ub; sr = sa + sb;
      cf = (r > 65535);
      af = ((ua % 16) + (ub % 16) > 15);
    end
    of_ = (sr > 32767) || (sr < -32768);
    res = r[15:0];
    return {of_, res[15], res == 16'h0, af, ~^res[7:0], cf};
  endfunction

  function automatic logic [15:0] pattern(input int k, input int i);
    logic [15:0] c;
    if (k % 4 == 0) begin
      case (i)
        0: c = 16'h7FFF; 1: c = 16'h0001; 2: c = 16'hFFFF; 3: c = 16'h8000;
        4: c = 16'h000F; 5: c = 16'h0000; 6: c = 16'h8001; default: c = 16'h00F1;
      endcase
    end else begin
      c = 16'((k * 40503 + i * 7919 + 4660) ^ (k << 5));
    end
    return c;
  endfunction

  task automatic preload(input int idx, input logic [15:0] v);
    @(negedge clk);
    ld_en_i = 1'b1; ld_idx_i = 3'(idx); ld_data_i = v;
    @(negedge clk);
    ld_en_i = 1'b0;
    model[idx] = v;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      obs_idx_i = 3'(i);
      #0.1;
      check($sformatf("%s reg%0d", req, i), {16'h0, obs_data_o}, {16'h0, model[i]});
    end
  endtask

  // inject: start with other indices and a preload during the read cycle
  task automatic run_op(input bit op, input int d, input int s, input bit inject, input string req);
    int cnt;
    logic [15:0] a, dv, sv;
    @(negedge clk);
    start_i = 1'b1; op_i = op; dst_i = 3'(d); src_i = 3'(s);
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      start_i = 1'b1; op_i = ~op; dst_i = 3'(s + 3); src_i = 3'(d + 5);
      ld_en_i = 1'b1; ld_idx_i = 3'(d + 1); ld_data_i = 16'hDEAD;
    end
    cnt = 1;
    while (!done_o && cnt < 20) begin
      @(negedge clk);
      start_i = 1'b0; ld_en_i = 1'b0;
      cnt++;
    end
    check({req, " R8 latency"}, cnt, op ? 3 : 4);
    dv = model[d]; sv = model[s]; a = model[0];
    if (!op) begin
      exp_flags = ref_flags(1'b0, dv, sv);
      model[s] = dv;
      model[d] = dv + sv;
    end else begin
      exp_flags = ref_flags(1'b1, a, dv);
      if (a == dv) model[d] = sv;
      else model[0] = dv;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({req, " R8/R9 no extra done"}, {31'h0, done_o}, 32'h0);
    end
    check({req, op ? " R5 flags" : " R4 flags"}, {26'h0, flags_o}, {26'h0, exp_flags});
    if (op) check({req, " R6/R7 zero flag"}, {31'h0, flags_o[3]}, {31'h0, a == dv});
    check_regs(req);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] held;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags", {26'h0, flags_o}, 32'h0);
    check("R1 done", {31'h0, done_o}, 32'h0);
    check("R1 busy", {31'h0, busy_o}, 32'h0);
    check_regs("R1");
    rst_n = 1'b1;

    // R10 preload while idle
    preload(3, 16'hA5A5);
    check_regs("R10 idle preload");

    // exchange-add over every index pair (R2 distinct, R3 aliased)
    for (int d = 0; d < 8; d++) begin
      for (int s = 0; s < 8; s++) begin
        int k = d * 8 + s;
        for (int i = 0; i < 8; i++) preload(i, pattern(k, i));
        run_op(1'b0, d, s, (k % 5 == 2), (d == s) ? "R3 xadd alias" : "R2 xadd");
      end
    end

    // R11 flags hold across preloads
    held = flags_o;
    preload(6, 16'h1357);
    preload(0, 16'h0000);
    check("R11 flags held", {26'h0, flags_o}, {26'h0, held});

    // compare-exchange over every index pair; even runs force equality
    for (int d = 0; d < 8; d++) begin
      for (int s = 0; s < 8; s++) begin
        int k = d * 8 + s + 64;
        for (int i = 0; i < 8; i++) preload(i, pattern(k, i));
        if ((k % 2 == 0) && d != 0) preload(0, model[d]);
        run_op(1'b1, d, s, (k % 5 == 1),
               (model[0] == model[d]) ? "R6 cmpx equal" : "R7 cmpx unequal");
      end
    end

    // R9/R10 explicit: start and preload during busy do not act
    for (int i = 0; i < 8; i++) preload(i, 16'(i * 257 + 1));
    run_op(1'b0, 2, 4, 1'b1, "R9 R10 busy guard");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule